// File: doc/BRIEF.md
# Scattered-Map 64-Source Interrupt Controller

This block collects 64 interrupt source lines into two 32-bit banks, a high bank and a low bank. Each bank has a mask register and a pending register. Every source sits at a fixed bank and bit, but the placement does not follow the source number arithmetically: the bit order is reversed in some ranges and ascending in others. Each source also has a 2-bit sense code that selects a level or edge condition. The controller keeps the lowest-numbered unmasked pending source in a vector register and drives one registered request line to the processor.

Software reaches the block through a simple synchronous register port. A write takes effect at the clock edge where `bus_we` is high. Read data comes out of a register one cycle after the address is presented. To bring the block up, software writes zero to both mask registers and then writes all-ones to both pending registers.

Top module: `scatter_irq_ctrl`

## Requirements
- R1: After reset, both mask registers, both pending registers and the vector read as zero, all sense codes are zero, and `irq_o` is low.
- R2: Source s sets exactly one pending bit. Sources 1–15 go to high bit 16−s. Sources 16–18 go to low bit 18−s. Sources 19–30 go to low bit 33−s. Sources 32–47 go to high bit 63−s. Sources 48–63 go to low bit s−32.
- R3: A mask bit of 0 keeps its source out of the vector and off `irq_o`, but its pending bit still sets. A mask bit of 1 enables the source.
- R4: Writing a 1 to a pending bit clears it, and writing a 0 leaves it unchanged. Writing zero masks and then all-ones to both pending registers leaves nothing pending and nothing requested.
- R5: A vector read returns the selected source number in bits 31:26, with all other bits zero. The value zero means nothing is pending. When several enabled sources are pending, the lowest source number is reported.
- R6: Sense code 0 makes a low line pending, and sense code 1 makes a high line pending. For these level sources, a pending bit cleared while the line is still active sets again.
- R7: Sense code 2 sets pending on a 1→0 transition, and code 3 sets it on a 0→1 transition. Once such a bit is cleared, it stays clear while the line holds steady.
- R8: Sources 0 and 31 are reserved. They never set a pending bit and are never reported as the vector.
- R9: `irq_o` is high one cycle after any pending bit is set together with its mask bit in either bank, and low one cycle after no such bit remains.
- R10: The register word offsets are: 0 high mask, 1 low mask, 2 high pending, 3 low pending, 4 vector (read-only), and 5–8 sense. Source s has its sense code at offset 5+s/16, bits 2(s mod 16)+1 : 2(s mod 16). `bus_rdata` returns the addressed register one cycle after the address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 64 | Interrupt source lines, bit s is source s |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Registered interrupt request to the processor |

## Verification
The hardest condition to reach from the ports is a pending bit that is cleared and set in the same cycle. This only happens when a level source is still active while software writes its clear. The bench reaches it by switching one source to level sense while its line is already active, issuing the clear, and reading the bank back. It then drops the line and clears again to show the bit stays clear. The scattered bank and bit placement is checked one source at a time from every mapping range, with single rising pulses under edge sense, so that each pending read holds exactly one bit.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NSRC     = 64;
  localparam int BANK_W   = 32;
  localparam int SENSE_W  = 2;
  localparam int VEC_W    = $clog2(NSRC);
  localparam int PER_WORD = BANK_W / SENSE_W;
  localparam int SENSE_WORDS = NSRC / PER_WORD;

  typedef enum logic [SENSE_W-1:0] {
    SENSE_LVL_LO = 2'd0,
    SENSE_LVL_HI = 2'd1,
    SENSE_FALL   = 2'd2,
    SENSE_RISE   = 2'd3
  } sense_e;

  // bank selection: groups of 16 alternate high, low, high, low
  function automatic logic src_in_high(input int s);
    return ((s / 16) % 2) == 0;
  endfunction

  function automatic int src_bit(input int s);
    int b;
    if (s < 16)      b = (16 - s) % 16;
    else if (s < 19) b = 18 - s;
    else if (s < 31) b = 33 - s;
    else if (s < 32) b = 0;
    else if (s < 48) b = 63 - s;
    else             b = s - 32;
    return b;
  endfunction

  function automatic logic src_reserved(input int s);
    return (s == 0) || (s == 31);
  endfunction
endpackage

// File: rtl/irqc_sense.sv
module irqc_sense
  import irqc_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [N-1:0]              line_i,
  input  logic [N-1:0][SENSE_W-1:0] sense_i,
  output logic [N-1:0]              event_o
);
  logic [N-1:0] line_q;

  always_ff @(posedge clk) begin
    line_q <= line_i;
  end

  for (genvar s = 0; s < N; s++) begin : g_src
    always_comb begin
      unique case (sense_e'(sense_i[s]))
        SENSE_LVL_LO: event_o[s] = ~line_i[s];
        SENSE_LVL_HI: event_o[s] =  line_i[s];
        SENSE_FALL:   event_o[s] =  line_q[s] & ~line_i[s];
        default:      event_o[s] = ~line_q[s] &  line_i[s];
      endcase
    end
  end

  // R7: an edge event needs the line to differ from its last sample
  assert_edge_needs_change_R7: assert property (@(posedge clk) disable iff (rst)
    (sense_i[1][1] && event_o[1]) |-> (line_q[1] != line_i[1]));
endmodule

// File: rtl/irqc_lowest_first.sv
module irqc_lowest_first #(
  parameter int N  = 64,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end

  assign found_o = |req_i;
endmodule

// File: rtl/scatter_irq_ctrl.sv
module scatter_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   src_i,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BANK_W-1:0] bus_wdata,
  output logic [BANK_W-1:0] bus_rdata,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_MASK_HI = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_MASK_LO = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_PEND_HI = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_PEND_LO = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_VEC     = ADDR_W'(4);
  localparam int                A_SENSE0  = 5;

  logic [BANK_W-1:0] mask_hi, mask_lo, pend_hi, pend_lo;
  logic [BANK_W-1:0] set_hi, set_lo, clr_hi, clr_lo;
  logic [NSRC-1:0][SENSE_W-1:0] sense_q;
  logic [NSRC-1:0]   src_event, live;
  logic              win_found;
  logic [VEC_W-1:0]  win_idx, vec_q;

  irqc_sense #(.N(NSRC)) u_sense (
    .clk(clk), .rst(rst), .line_i(src_i), .sense_i(sense_q), .event_o(src_event)
  );

  // steer each source event to its scattered bank position
  always_comb begin
    set_hi = '0;
    set_lo = '0;
    for (int s = 0; s < NSRC; s++) begin
      if (!src_reserved(s)) begin
        if (src_in_high(s)) set_hi[src_bit(s)] = set_hi[src_bit(s)] | src_event[s];
        else                set_lo[src_bit(s)] = set_lo[src_bit(s)] | src_event[s];
      end
    end
  end

  assign clr_hi = (bus_we && bus_addr == A_PEND_HI) ? bus_wdata : '0;
  assign clr_lo = (bus_we && bus_addr == A_PEND_LO) ? bus_wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_hi <= '0;
      mask_lo <= '0;
      pend_hi <= '0;
      pend_lo <= '0;
      sense_q <= '0;
    end else begin
      if (bus_we && bus_addr == A_MASK_HI) mask_hi <= bus_wdata;
      if (bus_we && bus_addr == A_MASK_LO) mask_lo <= bus_wdata;
      // a fresh event wins over a same-cycle clear
      pend_hi <= (pend_hi & ~clr_hi) | set_hi;
      pend_lo <= (pend_lo & ~clr_lo) | set_lo;
      for (int k = 0; k < SENSE_WORDS; k++) begin
        if (bus_we && bus_addr == ADDR_W'(A_SENSE0 + k))
          sense_q[k*PER_WORD +: PER_WORD] <= bus_wdata;
      end
    end
  end

  // gather enabled pending state back into source order
  always_comb begin
    live = '0;
    for (int s = 0; s < NSRC; s++) begin
      if (!src_reserved(s)) begin
        if (src_in_high(s)) live[s] = pend_hi[src_bit(s)] & mask_hi[src_bit(s)];
        else                live[s] = pend_lo[src_bit(s)] & mask_lo[src_bit(s)];
      end
    end
  end

  irqc_lowest_first #(.N(NSRC), .IW(VEC_W)) u_pick (
    .req_i(live), .found_o(win_found), .idx_o(win_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_q <= '0;
      irq_o <= 1'b0;
    end else begin
      vec_q <= win_found ? win_idx : '0;
      irq_o <= |(pend_hi & mask_hi) | |(pend_lo & mask_lo);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      bus_rdata <= '0;
      case (bus_addr)
        A_MASK_HI: bus_rdata <= mask_hi;
        A_MASK_LO: bus_rdata <= mask_lo;
        A_PEND_HI: bus_rdata <= pend_hi;
        A_PEND_LO: bus_rdata <= pend_lo;
        A_VEC:     bus_rdata <= {vec_q, {(BANK_W-VEC_W){1'b0}}};
        default: begin
          for (int k = 0; k < SENSE_WORDS; k++)
            if (bus_addr == ADDR_W'(A_SENSE0 + k))
              bus_rdata <= sense_q[k*PER_WORD +: PER_WORD];
        end
      endcase
    end
  end

  // R5: request line and vector agree on whether anything is selected
  assert_irq_vec_agree_R5: assert property (@(posedge clk) disable iff (rst)
    irq_o == (vec_q != '0));

  // R8: source 0 is the only user of high bit 0 and must never pend
  assert_reserved_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !pend_hi[0]);

  // R4: a cleared bit stays clear unless an event arrived in the same cycle
  assert_w1c_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == A_PEND_HI) |=>
      ((pend_hi & $past(bus_wdata) & ~$past(set_hi)) == '0));

  // R2: pending bits only appear where an event was steered
  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend_lo & ~$past(pend_lo) & ~$past(set_lo)) == '0));

  // R3: the request can only rise with some mask bit enabled
  assert_mask_gates_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> ($past(mask_hi | mask_lo) != '0));
endmodule

// File: tb/scatter_irq_ctrl_tb.sv
module scatter_irq_ctrl_tb;
  localparam int AW = 4;
  logic clk = 1'b0;
  logic rst;
  logic [63:0] src;
  logic we;
  logic [AW-1:0] addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic irq;
  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  scatter_irq_ctrl #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .src_i(src), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    addr = AW'(a);
    @(negedge clk);
    d = rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  // expected placement per R2: {high?, bit}
  function automatic logic [5:0] place(input int s);
    logic hi;
    int b;
    if (s >= 1 && s <= 15)       begin hi = 1; b = 16 - s; end
    else if (s >= 16 && s <= 18) begin hi = 0; b = 18 - s; end
    else if (s >= 19 && s <= 30) begin hi = 0; b = 33 - s; end
    else if (s >= 32 && s <= 47) begin hi = 1; b = 63 - s; end
    else                         begin hi = 0; b = s - 32; end
    return {hi, 5'(b)};
  endfunction

  task automatic pulse_up(input int s);
    @(negedge clk); src[s] = 1'b0;
    @(negedge clk); src[s] = 1'b1;
    settle();
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 5; a++) begin
      rd(a, d);
      check("R1 reg", d, 32'h0);
    end
    for (int a = 5; a < 9; a++) begin
      rd(a, d);
      check("R1 sense", d, 32'h0);
    end
    check("R1 irq", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_bringup();
    logic [31:0] d;
    for (int a = 5; a < 9; a++) wr(a, 32'hFFFF_FFFF);   // all rising edge
    rd(6, d);
    check("R10 sense readback", d, 32'hFFFF_FFFF);
    wr(0, 32'h0); wr(1, 32'h0);
    wr(2, 32'hFFFF_FFFF); wr(3, 32'hFFFF_FFFF);
    settle();
    rd(2, d); check("R4 bringup hi", d, 32'h0);
    rd(3, d); check("R4 bringup lo", d, 32'h0);
    check("R4 bringup irq", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_mapping();
    int list[10] = '{1, 15, 16, 18, 19, 30, 32, 47, 48, 63};
    logic [31:0] dh, dl, eh, el;
    logic [5:0] p;
    foreach (list[i]) begin
      pulse_up(list[i]);
      p = place(list[i]);
      eh = p[5] ? (32'h1 << p[4:0]) : 32'h0;
      el = p[5] ? 32'h0 : (32'h1 << p[4:0]);
      rd(2, dh); rd(3, dl);
      check($sformatf("R2 src%0d hi", list[i]), dh, eh);
      check($sformatf("R2 src%0d lo", list[i]), dl, el);
      wr(2, 32'hFFFF_FFFF); wr(3, 32'hFFFF_FFFF);
    end
  endtask

  task automatic t_reserved();
    logic [31:0] d;
    pulse_up(0);
    pulse_up(31);
    rd(2, d); check("R8 hi", d, 32'h0);
    rd(3, d); check("R8 lo", d, 32'h0);
  endtask

  task automatic t_mask_vec();
    logic [31:0] d;
    @(negedge clk); src[40] = 1'b0; src[20] = 1'b0;
    @(negedge clk); src[40] = 1'b1; src[20] = 1'b1;
    settle();
    rd(2, d); check("R3 pend hi while masked", d, 32'h1 << 23);
    rd(3, d); check("R3 pend lo while masked", d, 32'h1 << 13);
    rd(4, d); check("R3 vec masked", d, 32'h0);
    check("R3 irq masked", {31'h0, irq}, 32'h0);
    wr(0, 32'hFFFF_FFFF); settle();
    check("R9 irq on", {31'h0, irq}, 32'h1);
    rd(4, d); check("R5 vec 40", d, 32'd40 << 26);
    wr(1, 32'hFFFF_FFFF); settle();
    rd(4, d); check("R5 lowest wins 20", d, 32'd20 << 26);
    wr(3, 32'h1 << 13); settle();
    rd(4, d); check("R4 w1c lo -> vec 40", d, 32'd40 << 26);
    wr(2, 32'h0); settle();
    rd(2, d); check("R4 write zero no effect", d, 32'h1 << 23);
    wr(2, 32'h1 << 23); settle();
    rd(4, d); check("R5 vec empty", d, 32'h0);
    check("R9 irq off", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    wr(5, 32'hFFFF_FFFF & ~(32'h2 << 10));   // src5 level-high, line is high
    settle();
    rd(4, d); check("R6 level-high vec 5", d, 32'd5 << 26);
    wr(2, 32'h1 << 11); settle();
    rd(2, d); check("R6 level-high re-sets", d, 32'h1 << 11);
    @(negedge clk); src[5] = 1'b0;
    wr(2, 32'h1 << 11); settle();
    rd(2, d); check("R6 level-high cleared", d, 32'h0);
    wr(8, 32'hFFFF_FFFF & ~(32'h3 << 4));    // src50 level-low, line high
    settle();
    rd(3, d); check("R6 level-low idle", d, 32'h0);
    @(negedge clk); src[50] = 1'b0; settle();
    rd(4, d); check("R6 level-low vec 50", d, 32'd50 << 26);
    wr(3, 32'h1 << 18); settle();
    rd(3, d); check("R6 level-low re-sets", d, 32'h1 << 18);
    @(negedge clk); src[50] = 1'b1;
    wr(3, 32'h1 << 18); settle();
    rd(3, d); check("R6 level-low cleared", d, 32'h0);
    check("R9 irq idle", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_falling();
    logic [31:0] d;
    wr(7, 32'hFFFF_FFFF & ~(32'h1 << 2));    // src33 falling edge
    settle();
    rd(2, d); check("R7 no event on config", d, 32'h0);
    @(negedge clk); src[33] = 1'b0; settle();
    rd(2, d); check("R7 falling sets", d, 32'h1 << 30);
    rd(4, d); check("R7 vec 33", d, 32'd33 << 26);
    wr(2, 32'h1 << 30); settle();
    rd(2, d); check("R7 stays clear while low", d, 32'h0);
    @(negedge clk); src[33] = 1'b1; settle();
    rd(2, d); check("R7 rising ignored", d, 32'h0);
  endtask

  initial begin
    rst = 1'b1; src = '1; we = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_bringup();
    t_mapping();
    t_reserved();
    t_mask_vec();
    t_level();
    t_falling();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule